// File: doc/BRIEF.md
# Paired-Bit Carry-Chain Unsigned Multiplier

This block is a purely combinational unsigned multiplier that takes an even-width operand `xOp` and an operand `yOp` and returns their full-width product. It is laid out for fabrics built from small lookup tables feeding a dedicated carry chain. The multiplier bits are taken two at a time, so each group of two bits yields a single partial-product row. A row forms the sum of one copy of `yOp` and one copy of `yOp` shifted left by one. The choice of copies depends on the two selecting bits.

Every row is a ripple chain of M+1 identical cells. Each cell compares its two addend bits with a propagate function and then steers the carry with a two-way select. After the rows are weighted by powers of four, a chain of full-adder 3:2 compressors reduces them to a sum vector and a carry vector. A ripple-carry adder then merges those two vectors into the product. The operand widths are parameters, and the default configuration is 6 by 4 bits.

Top module: `pmul_top`

## Requirements
- R1: `product` equals the unsigned value of `xOp` times `yOp`, written into N+M bits with no truncation, for every pair of input values.
- R2: When either operand is zero, `product` is zero.
- R3: Suppose only one bit pair (bits 2k+1 and 2k) of `xOp` is non-zero and holds the value v. Then `product` equals v·`yOp`·4^k, which shows that each row computes (2·x(2k+1) + x(2k))·Y.
- R4: Suppose only the low bit of each bit pair of `xOp` can be set. Then each row adds only x(2k)·Y, the carry out of its top cell is zero, and `product` equals `xOp`·`yOp`.
- R5: When both operands are all ones, `product` equals (2^N−1)·(2^M−1), so the final adder carries across its full width.
- R6: The carry-save reduction preserves the value. Its sum and carry vectors add, modulo 2^(N+M), to the total of the weighted row results.
- R7: The final two-operand adder returns the sum of its inputs modulo 2^(N+M).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xOp | input | N | Multiplier operand, taken in bit pairs; N must be even |
| yOp | input | M | Multiplicand operand |
| product | output | N+M | Unsigned product xOp·yOp |

## Verification
The embedded checks assume that both operands hold known, stable binary values. They also assume that the block settles completely before any output is compared, because nothing in the design is clocked. The bench changes the inputs only on one clock edge and compares the outputs half a period later. It sweeps every pair of operand values for the default 6 by 4 configuration. It also runs single-pair and low-bits-only patterns, which isolate individual rows and the top-cell carry.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  // Default operand widths; the multiplier operand must be even.
  localparam int DefXWidth = 6;
  localparam int DefYWidth = 4;

  // Majority of three bits, the carry of a full adder.
  function automatic logic majority3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/pmul_row.sv
// One partial-product row: (2*xPair[1] + xPair[0]) * y, built from M+1 cells.
module pmul_row #(
  parameter int M = pmul_pkg::DefYWidth
) (
  input  logic [M-1:0] y,
  input  logic [1:0]   xPair,
  output logic [M+1:0] rowSum
);
  logic [M+1:0] chain;  // chain[j] is carry into cell j
  logic [M:0]   cellSum;

  assign chain[0] = 1'b0;

  for (genvar j = 0; j <= M; j++) begin : g_cell
    logic addLo;   // x(2k) * y(j)
    logic addHi;   // x(2k+1) * y(j-1)
    logic prop;
    if (j < M) begin : g_lo
      assign addLo = xPair[0] & y[j];
    end else begin : g_lo_edge
      assign addLo = 1'b0;
    end
    if (j > 0) begin : g_hi
      assign addHi = xPair[1] & y[j-1];
    end else begin : g_hi_edge
      assign addHi = 1'b0;
    end
    // Lookup-table part: propagate of the two addend bits.
    assign prop = addLo ^ addHi;
    // Carry-chain part: xor for the sum, select for the carry.
    assign cellSum[j]  = prop ^ chain[j];
    assign chain[j+1]  = prop ? chain[j] : addLo;
  end

  assign rowSum = {chain[M+1], cellSum};

  always_comb begin
    // p_row_idle_r2: a row with no selecting bit contributes nothing
    if (xPair == 2'b00)
      p_row_idle_r2: assert (rowSum == '0) else $error("row not zero with idle pair");
    // p_row_topcarry_r4: the top carry stays low when only the low bit selects
    if (xPair[1] == 1'b0)
      p_row_topcarry_r4: assert (rowSum[M+1:M] == 2'b00) else $error("row top bits set with x(2k+1)=0");
  end
endmodule

// File: rtl/pmul_csa_tree.sv
// Full-adder carry-save reduction of OPS operands down to two vectors.
module pmul_csa_tree #(
  parameter int OPS = 3,
  parameter int W   = 10
) (
  input  logic [OPS-1:0][W-1:0] ops,
  output logic [W-1:0]          sumVec,
  output logic [W-1:0]          carryVec
);
  if (OPS == 1) begin : g_single
    assign sumVec   = ops[0];
    assign carryVec = '0;
  end else begin : g_chain
    logic [OPS-1:0][W-1:0] sPart;
    logic [OPS-1:0][W-1:0] cPart;
    assign sPart[0] = '0;
    assign cPart[0] = '0;
    assign sPart[1] = ops[0];
    assign cPart[1] = ops[1];
    for (genvar i = 2; i < OPS; i++) begin : g_stage
      logic [W-1:0] maj;
      for (genvar b = 0; b < W; b++) begin : g_fa
        assign sPart[i][b] = sPart[i-1][b] ^ cPart[i-1][b] ^ ops[i][b];
        assign maj[b]      = pmul_pkg::majority3(sPart[i-1][b], cPart[i-1][b], ops[i][b]);
      end
      assign cPart[i] = {maj[W-2:0], 1'b0};
    end
    assign sumVec   = sPart[OPS-1];
    assign carryVec = cPart[OPS-1];
  end

  logic [W-1:0] opsTotal;
  always_comb begin
    opsTotal = '0;
    for (int i = 0; i < OPS; i++) opsTotal = opsTotal + ops[i];
    // p_csa_value_r6: reduction keeps the operand total modulo 2^W
    p_csa_value_r6: assert (W'(sumVec + carryVec) == opsTotal) else $error("carry-save total mismatch");
  end
endmodule

// File: rtl/pmul_ripple.sv
// Two-operand ripple-carry adder, result modulo 2^W.
module pmul_ripple #(
  parameter int W = 10
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = opA[i] ^ opB[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = pmul_pkg::majority3(opA[i], opB[i], cy[i]);
    end
  end

  always_comb begin
    // p_adder_sum_r7: adder result matches the modular sum of its inputs
    p_adder_sum_r7: assert (sum == W'(opA + opB)) else $error("ripple adder mismatch");
  end
endmodule

// File: rtl/pmul_top.sv
module pmul_top #(
  parameter int N = pmul_pkg::DefXWidth,
  parameter int M = pmul_pkg::DefYWidth
) (
  input  logic [N-1:0]   xOp,
  input  logic [M-1:0]   yOp,
  output logic [N+M-1:0] product
);
  localparam int Rows = N / 2;
  localparam int PW   = N + M;
  localparam int RW   = M + 2;

  logic [Rows-1:0][RW-1:0] rowOut;
  logic [Rows-1:0][PW-1:0] weighted;
  logic [PW-1:0]           redSum;
  logic [PW-1:0]           redCarry;

  for (genvar k = 0; k < Rows; k++) begin : g_row
    pmul_row #(.M(M)) row_i (
      .y      (yOp),
      .xPair  (xOp[2*k+1 -: 2]),
      .rowSum (rowOut[k])
    );
    assign weighted[k] = PW'(rowOut[k]) << (2 * k);
  end

  pmul_csa_tree #(.OPS(Rows), .W(PW)) tree_i (
    .ops      (weighted),
    .sumVec   (redSum),
    .carryVec (redCarry)
  );

  pmul_ripple #(.W(PW)) adder_i (
    .opA (redSum),
    .opB (redCarry),
    .sum (product)
  );

  always_comb begin
    // p_product_r1: the output equals the full product
    p_product_r1: assert (product == PW'(PW'(xOp) * PW'(yOp))) else $error("product mismatch");
    // p_zero_r2: a zero operand yields zero
    if (xOp == '0 || yOp == '0)
      p_zero_r2: assert (product == '0) else $error("zero operand gave non-zero product");
  end
endmodule

// File: tb/pmul_top_tb_top.sv
module pmul_top_tb_top;
  localparam int N  = 6;
  localparam int M  = 4;
  localparam int PW = N + M;

  logic clk = 1'b0;
  always #5 clk = ~clk;  // 100 MHz

  logic [N-1:0]  xOp;
  logic [M-1:0]  yOp;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pmul_top #(.N(N), .M(M)) dut_i (
    .xOp     (xOp),
    .yOp     (yOp),
    .product (product)
  );

  task automatic apply(input int xv, input int yv, input int expv, input string tag);
    @(posedge clk);
    xOp = N'(xv);
    yOp = M'(yv);
    @(negedge clk);
    checks++;
    if (product !== PW'(expv)) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d actual=%0d expected=%0d", tag, xv, yv, product, expv);
    end
  endtask

  initial begin
    xOp = '0;
    yOp = '0;
    // R2: start-up state, both operands zero
    apply(0, 0, 0, "R2");
    // R2: one operand zero, the other swept
    for (int v = 0; v < (1 << M); v++) apply(0, v, 0, "R2");
    for (int v = 0; v < (1 << N); v++) apply(v, 0, 0, "R2");
    // R3: isolate each row with every pair value
    for (int k = 0; k < N / 2; k++)
      for (int pv = 1; pv < 4; pv++)
        for (int yv = 0; yv < (1 << M); yv++)
          apply(pv << (2 * k), yv, pv * yv * (1 << (2 * k)), "R3");
    // R4: only low bits of each pair set (mask 0b010101)
    for (int xv = 0; xv < (1 << N); xv++)
      if ((xv & 'h2A) == 0)
        for (int yv = 0; yv < (1 << M); yv++) apply(xv, yv, xv * yv, "R4");
    // R5: all ones on both operands
    apply((1 << N) - 1, (1 << M) - 1, ((1 << N) - 1) * ((1 << M) - 1), "R5");
    // R6/R7: all rows active with carries, reduction and final add exercised
    apply('h3F, 'hB, 'h3F * 'hB, "R6");
    apply('h2A, 'hF, 'h2A * 'hF, "R7");
    // R1: exhaustive sweep
    for (int xv = 0; xv < (1 << N); xv++)
      for (int yv = 0; yv < (1 << M); yv++) apply(xv, yv, xv * yv, "R1");
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule